// File: doc/BRIEF.md
# Power-Up Serial Mode Loader

This block fetches the fundamental operating modes of a processor from a slow serial source, such as a small serial memory or a simple logic device, when power comes up. It waits for the power-good input. Once that input is high, it drives a serial clock that runs at the master clock divided by 2^`DIV_LOG2` (256 by default). It takes one data bit per serial clock period until `NUM_BITS` bits (256 by default) have been collected. It then presents them as a parallel mode vector and raises a done flag.

After the load completes, the serial clock keeps running but the mode vector is frozen, so further serial data has no effect. If power-good drops, the loader returns to its idle state. When power-good rises again, a fresh load starts from the first bit. The meaning of the individual mode bits belongs to the consumer of the vector.

Top module: `boot_mode_loader`

## Requirements
- R1: After asynchronous reset, `ser_clk` is 0, `load_done` is 0 and `mode_vec` is all zeros.
- R2: While `pwr_good` is low, `ser_clk` stays 0, `load_done` stays 0 and `ser_din` is not captured. `ser_clk` and `load_done` are both 0 in the cycle after any cycle in which `pwr_good` was low.
- R3: While `pwr_good` is high, `ser_clk` has a period of 2^`DIV_LOG2` master cycles. It is low for the first half of each period and high for the second half. Its first rising edge is at the 2^(`DIV_LOG2`-1)-th master clock edge that sees `pwr_good` high.
- R4: Each serial bit is sampled from `ser_din` at the master clock edge at which `ser_clk` rises, so a source that changes data just after a rising edge of `ser_clk` is read correctly.
- R5: The first bit received is stored at `mode_vec[0]`, and bit k of the stream (counting from 0) ends up at `mode_vec[k]`.
- R6: `load_done` is first seen high after exactly 2^(`DIV_LOG2`-1) + (`NUM_BITS`-1)·2^`DIV_LOG2` master clock edges with `pwr_good` high. When it is seen high, all `NUM_BITS` bits are in place.
- R7: After `load_done` is high, `ser_clk` keeps toggling with the R3 period, and `mode_vec` does not change regardless of `ser_din`.
- R8: Dropping `pwr_good` during or after a load clears `load_done` and the bit position. A later rise of `pwr_good` loads a complete new stream starting from bit 0.
- R9: `load_done` stays high for as long as `pwr_good` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Power-good level; high starts and enables loading |
| ser_din | input | 1 | Serial mode data from the external source |
| ser_clk | output | 1 | Divided serial clock for the external source |
| mode_vec | output | NUM_BITS | Captured mode bits, first received bit at index 0 |
| load_done | output | 1 | High once all mode bits are captured |

## Verification
The serial clock rises 2^(`DIV_LOG2`-1) edges after power-good is first sampled high. One bit is then taken per 2^`DIV_LOG2` edges, and the done flag is due exactly 2^(`DIV_LOG2`-1) + (`NUM_BITS`-1)·2^`DIV_LOG2` edges after that first sample. Power-good low clears the serial clock and the done flag one edge later.

The bench counts master clock edges from the cycle it raises power-good and compares that count against these numbers. It samples every output at the falling master edge, half a cycle after the register that drives it. It changes serial data right after each serial clock rise, so a sample taken a cycle early or late captures the wrong bit. A small configuration (divide by 4, 8 bits) is swept over all 256 patterns. The default configuration is loaded once with a computed pattern.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  // Default configuration: divide-by-256 serial clock, 256 mode bits.
  localparam int unsigned DEF_DIV_LOG2 = 8;
  localparam int unsigned DEF_NUM_BITS = 256;

  // Width of a counter able to index n positions (at least one bit).
  function automatic int unsigned index_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/boot_clk_divider.sv
// Free-running prescaler for the serial clock. The serial clock is the
// counter MSB, so it comes straight from a flop and cannot glitch. The
// strobe marks the master edge at which the serial clock rises.
module boot_clk_divider #(
  parameter int unsigned DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ser_clk,
  output logic rise_strobe
);

  localparam int unsigned HALF = 1 << (DIV_LOG2 - 1);
  localparam logic [DIV_LOG2-1:0] RISE_AT = DIV_LOG2'(HALF - 1);

  logic [DIV_LOG2-1:0] div_q;
  logic [DIV_LOG2-1:0] div_d;

  // next state
  always_comb begin
    if (run) begin
      div_d = div_q + 1'b1;
    end else begin
      div_d = '0;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign ser_clk     = div_q[DIV_LOG2-1];
  assign rise_strobe = run && (div_q == RISE_AT);

endmodule

// File: rtl/boot_bit_counter.sv
// Tracks how many mode bits have been taken and raises done with the last
// one. Once done, the capture enable is held off for good.
module boot_bit_counter #(
  parameter int unsigned NUM_BITS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rise_strobe,
  output logic capture_en,
  output logic done
);

  import boot_mode_pkg::*;

  localparam int unsigned CNT_W = index_width(NUM_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             done_q;
  logic             done_d;

  assign capture_en = rise_strobe && !done_q;

  // next state
  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!run) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (capture_en) begin
      if (cnt_q == LAST_IDX) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/boot_shift_capture.sv
// Right-shifting capture register: each new bit enters at the top, so after
// NUM_BITS shifts the first bit received sits at index 0.
module boot_shift_capture #(
  parameter int unsigned NUM_BITS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture_en,
  input  logic                din,
  output logic [NUM_BITS-1:0] vec
);

  logic [NUM_BITS-1:0] vec_q;
  logic [NUM_BITS-1:0] vec_d;

  // next state
  always_comb begin
    if (capture_en) begin
      vec_d = {din, vec_q[NUM_BITS-1:1]};
    end else begin
      vec_d = vec_q;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else begin
      vec_q <= vec_d;
    end
  end

  assign vec = vec_q;

endmodule

// File: rtl/boot_mode_loader.sv
// Power-up serial mode loader: top level.
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int unsigned DIV_LOG2 = DEF_DIV_LOG2,
  parameter int unsigned NUM_BITS = DEF_NUM_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_good,
  input  logic                ser_din,
  output logic                ser_clk,
  output logic [NUM_BITS-1:0] mode_vec,
  output logic                load_done
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic rise_strobe;
  logic capture_en;

  boot_clk_divider #(
    .DIV_LOG2(DIV_LOG2)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (pwr_good),
    .ser_clk    (ser_clk),
    .rise_strobe(rise_strobe)
  );

  boot_bit_counter #(
    .NUM_BITS(NUM_BITS)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (pwr_good),
    .rise_strobe(rise_strobe),
    .capture_en (capture_en),
    .done       (load_done)
  );

  boot_shift_capture #(
    .NUM_BITS(NUM_BITS)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture_en(capture_en),
    .din       (ser_din),
    .vec       (mode_vec)
  );

endmodule

// File: rtl/boot_mode_loader_chk.sv
// Port-level properties of the loader, attached by bind.
module boot_mode_loader_chk #(
  parameter int unsigned NUM_BITS = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_good,
  input logic                ser_clk,
  input logic [NUM_BITS-1:0] mode_vec,
  input logic                load_done
);

  // R2: power-good low forces the serial clock and done flag low next cycle
  assert_idle_when_unpowered_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!ser_clk && !load_done));

  // R3: the serial clock only rises on an edge that saw power-good high
  assert_clk_rise_powered_R3: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $past(pwr_good));

  // R7: the mode vector is frozen once loading is complete
  assert_vec_frozen_R7: assert property (
    @(posedge clk) disable iff (!rst_n)
    load_done |=> $stable(mode_vec));

  // R9: done holds while power-good stays high
  assert_done_holds_R9: assert property (
    @(posedge clk) disable iff (!rst_n)
    (load_done && pwr_good) |=> load_done);

  // R8: done can only rise after an edge that saw power-good high
  assert_done_rise_powered_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> $past(pwr_good));

endmodule

bind boot_mode_loader boot_mode_loader_chk #(
  .NUM_BITS(NUM_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_good (pwr_good),
  .ser_clk  (ser_clk),
  .mode_vec (mode_vec),
  .load_done(load_done)
);

// File: tb/boot_mode_loader_tb.sv
module boot_mode_loader_tb;

  localparam int S_LOG = 2;
  localparam int S_N = 8;
  localparam int S_DIV = 1 << S_LOG;
  localparam int S_HALF = S_DIV / 2;
  localparam int B_LOG = 8;
  localparam int B_N = 256;
  localparam int B_DIV = 1 << B_LOG;
  localparam int B_HALF = B_DIV / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic pg_b, din_b, sclk_b, done_b;
  logic [B_N-1:0] vec_b;
  logic pg_s, din_s, sclk_s, done_s;
  logic [S_N-1:0] vec_s;

  boot_mode_loader u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pg_b), .ser_din(din_b),
    .ser_clk(sclk_b), .mode_vec(vec_b), .load_done(done_b));

  boot_mode_loader #(.DIV_LOG2(S_LOG), .NUM_BITS(S_N)) u_small (
    .clk(clk), .rst_n(rst_n), .pwr_good(pg_s), .ser_din(din_s),
    .ser_clk(sclk_s), .mode_vec(vec_s), .load_done(done_s));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_small(input logic [S_N-1:0] pat, output int lat);
    int n;
    din_s = pat[0];
    @(negedge clk);
    pg_s = 1'b1;
    n = 0;
    fork
      begin
        for (int i = 0; i < S_N; i++) begin
          din_s = pat[i];
          @(posedge sclk_s);
        end
      end
      begin
        do begin
          @(posedge clk);
          n++;
          @(negedge clk);
        end while (!done_s && n < 1000);
      end
    join
    lat = n;
  endtask

  // R7: keep the serial source busy after done and count serial clock rises
  task automatic post_done_small(input logic [S_N-1:0] pat, input string tag);
    int rises;
    logic prev;
    rises = 0;
    prev = sclk_s;
    for (int c = 0; c < 3 * S_DIV; c++) begin
      din_s = ~din_s;
      @(negedge clk);
      if (sclk_s && !prev) rises++;
      prev = sclk_s;
    end
    chk(rises == 3, "R7", {tag, " serial clock rises after done"}, rises, 3);
    chk(vec_s == pat, "R7", {tag, " vector frozen after done"}, vec_s, pat);
    chk(done_s == 1'b1, "R9", {tag, " done held"}, done_s, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int n;
    logic [B_N-1:0] exp_b;
    bit quiet;

    rst_n = 1'b0;
    pg_b = 1'b0; din_b = 1'b0; pg_s = 1'b0; din_s = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(sclk_s == 1'b0 && done_s == 1'b0, "R1", "small clk/done in reset",
        {sclk_s, done_s}, 0);
    chk(vec_s == '0, "R1", "small vector in reset", vec_s, 0);
    chk(vec_b == '0 && sclk_b == 1'b0 && done_b == 1'b0, "R1",
        "default outputs in reset", done_b, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: unpowered, serial data wiggling, nothing moves
    quiet = 1'b1;
    for (int c = 0; c < 20; c++) begin
      din_s = ~din_s;
      @(negedge clk);
      if (sclk_s || done_s || vec_s != '0) quiet = 1'b0;
    end
    chk(quiet, "R2", "idle while power-good low", quiet, 1);

    // R3: first rise and duty cycle
    din_s = 1'b0;
    pg_s = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!sclk_s && n < 100);
    chk(n == S_HALF, "R3", "edges to first serial clock rise", n, S_HALF);
    n = 0;
    while (sclk_s && n < 100) begin @(negedge clk); n++; end
    chk(n == S_HALF, "R3", "serial clock high cycles", n, S_HALF);
    n = 0;
    while (!sclk_s && n < 100) begin @(negedge clk); n++; end
    chk(n == S_HALF, "R3", "serial clock low cycles", n, S_HALF);

    // R8: abort mid-load, then reload from bit 0
    pg_s = 1'b0;
    @(negedge clk);
    chk(!sclk_s && !done_s, "R8", "abort clears clock and done",
        {sclk_s, done_s}, 0);
    @(negedge clk);
    load_small(8'h3C, lat);
    chk(vec_s == 8'h3C, "R8", "reload after abort", vec_s, 8'h3C);
    pg_s = 1'b0;
    @(negedge clk);

    // R4 R5 R6: exhaustive sweep of small configuration
    for (int p = 0; p < 256; p++) begin
      load_small(S_N'(p), lat);
      chk(vec_s == S_N'(p), "R5", "bit order / R4 sample point", vec_s, p);
      chk(lat == S_HALF + (S_N - 1) * S_DIV, "R6", "done latency", lat,
          S_HALF + (S_N - 1) * S_DIV);
      if (p % 16 == 0) post_done_small(S_N'(p), "sweep");
      pg_s = 1'b0;
      @(negedge clk);
      chk(done_s == 1'b0, "R8", "done clears on power-good drop", done_s, 0);
    end

    // Default configuration: one full load
    for (int i = 0; i < B_N; i++) exp_b[i] = (((i * 13 + 5) % 7) < 3);
    din_b = exp_b[0];
    @(negedge clk);
    pg_b = 1'b1;
    n = 0;
    fork
      begin
        for (int i = 0; i < B_N; i++) begin
          din_b = exp_b[i];
          @(posedge sclk_b);
        end
      end
      begin
        do begin
          @(posedge clk);
          n++;
          @(negedge clk);
        end while (!done_b && n < 70000);
      end
    join
    chk(n == B_HALF + (B_N - 1) * B_DIV, "R6", "default done latency", n,
        B_HALF + (B_N - 1) * B_DIV);
    checks++;
    if (vec_b != exp_b) begin
      errors++;
      $display("FAIL R5 default vector actual=%h expected=%h", vec_b, exp_b);
    end
    // R7 on default configuration
    begin
      int rises;
      logic prev;
      rises = 0;
      prev = sclk_b;
      for (int c = 0; c < 2 * B_DIV; c++) begin
        din_b = ~din_b;
        @(negedge clk);
        if (sclk_b && !prev) rises++;
        prev = sclk_b;
      end
      chk(rises == 2, "R7", "default serial clock runs after done", rises, 2);
      checks++;
      if (vec_b != exp_b) begin
        errors++;
        $display("FAIL R7 default vector changed actual=%h expected=%h",
                 vec_b, exp_b);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule